// File: doc/BRIEF.md
# Serial IRQ Upstream Interrupt Selector

This block raises the interrupt that a management controller sends to the host for one mailbox channel. Software programs a slot number and a signalling type. Each time the controller writes the channel's outgoing data byte, a trigger pulse arrives and the block drives the chosen slot of a 16-slot request vector. A serial-IRQ frame serializer downstream reads that vector. The frame protocol itself lies outside this block.

There are three signalling types. Active-high level and active-low level keep the request present until it is cleared. Rising edge produces a single one-cycle request for each trigger. Before any setting reaches the slot, it is validated. A rejected setting leaves the slot quiet and sets an error flag that stays set.

Parameters select the variant:
- A restricted variant accepts only the two level types.
- A legacy variant ignores the programmable slot and drives two fixed slots, 1 and 12, each with its own enable.

The full variant also has an auto-clear bit. This bit lets the falling output-buffer-full flag withdraw a level request.

Top module: `sirq_upstream_sel`

## Requirements
- R1: After reset, `irq_line`, `assert_q`, `autoclr` and `cfg_err` are all zero, and no slot is selected.
- R2: A configuration write with `cfg_num` from 0 to 15 and a valid type selects that slot. A value of 16 or more is rejected, and `irq_line` stays all zero until a valid write arrives.
- R3: Type encodings are 2'b01 for active-high level, 2'b00 for active-low level, 2'b11 for rising edge and 2'b10 reserved. With an active-high level type, bit `cfg_num` of `irq_line` equals `assert_q`. With an active-low level type, that bit equals the inverse of `assert_q`. All other bits are 0.
- R4: In the level types, `trig` or `sw_set` sets `assert_q` at the next edge, and `sw_clr` clears it. A set and a clear in the same cycle leave it set. Any configuration write clears it.
- R5: In the rising-edge type, each cycle with `trig` or `sw_set` makes the selected bit 1 for exactly one cycle, and `assert_q` clears by itself.
- R6: A configuration write with type 2'b10, or with an out-of-range number, sets `cfg_err`. `cfg_err` then stays 1 until reset, and `irq_line` stays all zero even when triggered.
- R7: With `LEVEL_ONLY=1`, type 2'b11 is rejected in the same way as in R6.
- R8: In the full variant, `ac_wr` loads `autoclr` from `ac_val`, and any configuration write clears `autoclr`. While `autoclr` is 1, a 1-to-0 transition of `obf` clears `assert_q`. While `autoclr` is 0, that transition has no effect. With `LEVEL_ONLY=1`, `autoclr` always reads 0, and the `obf` fall always clears `assert_q`.
- R9: With `LEGACY=1`, `irq_line` bit 1 is `assert_q & leg_en_a` and bit 12 is `assert_q & leg_en_b`. All other bits are 0, whatever the programmed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_num | input | 5 | Requested slot number; values above 15 are invalid |
| cfg_type | input | 2 | Signalling type code |
| ac_wr | input | 1 | Auto-clear bit write strobe |
| ac_val | input | 1 | Auto-clear bit write value |
| leg_en_a | input | 1 | Legacy enable for slot 1 |
| leg_en_b | input | 1 | Legacy enable for slot 12 |
| trig | input | 1 | Output data register written |
| sw_set | input | 1 | Software sets the assert bit |
| sw_clr | input | 1 | Software clears the assert bit |
| obf | input | 1 | Output-buffer-full flag |
| irq_line | output | 16 | Per-slot request line levels |
| assert_q | output | 1 | Assert-enable bit |
| autoclr | output | 1 | Auto-clear control bit |
| cfg_err | output | 1 | Sticky invalid-configuration flag |

## Verification
The bench builds three instances from one set of stimulus, each with 16 slots:
- the full variant with default parameters;
- one with `LEVEL_ONLY=1`;
- one with `LEGACY=1`.

Running them together means a single rising-edge configuration is accepted by one instance and rejected by another. It also shows the fixed slots 1 and 12 being driven while the programmable slot is ignored. Out-of-range numbers up to 19 and random interleaving of triggers, clears and falls of `obf` exercise the priority between set and clear and the auto-clear path.

// File: rtl/sirq_upstream_sel.sv
module sirq_upstream_sel #(
  parameter int SLOTS      = 16,
  parameter bit LEVEL_ONLY = 1'b0,
  parameter bit LEGACY     = 1'b0,
  parameter int LEG_A      = 1,
  parameter int LEG_B      = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [$clog2(SLOTS):0]      cfg_num,
  input  logic [1:0]                  cfg_type,
  input  logic                        ac_wr,
  input  logic                        ac_val,
  input  logic                        leg_en_a,
  input  logic                        leg_en_b,
  input  logic                        trig,
  input  logic                        sw_set,
  input  logic                        sw_clr,
  input  logic                        obf,
  output logic [SLOTS-1:0]            irq_line,
  output logic                        assert_q,
  output logic                        autoclr,
  output logic                        cfg_err
);
  localparam int IDW = $clog2(SLOTS);
  localparam logic [1:0] T_LOW  = 2'b00;
  localparam logic [1:0] T_RSVD = 2'b10;
  localparam logic [1:0] T_RISE = 2'b11;
  localparam logic [IDW:0] NUM_MAX = (IDW+1)'(SLOTS-1);

  logic [IDW-1:0] id_q;
  logic [1:0]     ty_q;
  logic           ok_q;
  logic           obf_q;

  wire bad       = (cfg_num > NUM_MAX) || (cfg_type == T_RSVD) ||
                   (LEVEL_ONLY && cfg_type == T_RISE);
  wire set_req   = trig | sw_set;
  wire obf_fall  = obf_q & ~obf;
  wire edge_mode = !LEGACY && (ty_q == T_RISE);
  wire clr_req   = sw_clr | (obf_fall & (LEVEL_ONLY | autoclr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q     <= '0;
      ty_q     <= T_LOW;
      ok_q     <= 1'b0;
      obf_q    <= 1'b0;
      assert_q <= 1'b0;
      autoclr  <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      obf_q <= obf;
      if (cfg_wr) begin
        ok_q     <= ~bad;
        assert_q <= 1'b0;
        autoclr  <= 1'b0;
        cfg_err  <= cfg_err | bad;
        if (!bad) begin
          id_q <= cfg_num[IDW-1:0];
          ty_q <= cfg_type;
        end
      end else begin
        if (ac_wr && !LEVEL_ONLY) autoclr <= ac_val;
        if (edge_mode)    assert_q <= set_req;
        else if (set_req) assert_q <= 1'b1;
        else if (clr_req) assert_q <= 1'b0;
      end
    end
  end

  always_comb begin
    irq_line = '0;
    if (LEGACY) begin
      irq_line[LEG_A] = assert_q & leg_en_a;
      irq_line[LEG_B] = assert_q & leg_en_b;
    end else if (ok_q) begin
      irq_line[id_q] = (ty_q == T_LOW) ? ~assert_q : assert_q;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);  // R6
  AST_CFG_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !assert_q);  // R4
  AST_AC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !autoclr);  // R8
  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !LEGACY |-> $countones(irq_line) <= 1);  // R3
  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && bad && !LEGACY) |=> irq_line == '0);  // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && set_req && !edge_mode) |=> assert_q);  // R4
endmodule

// File: tb/sirq_upstream_sel_test.sv
module sirq_upstream_sel_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_wr = 0, ac_wr = 0, ac_val = 0, leg_en_a = 0, leg_en_b = 0;
  logic trig = 0, sw_set = 0, sw_clr = 0, obf = 0;
  logic [4:0] cfg_num = 0;
  logic [1:0] cfg_type = 0;

  logic [15:0] line [3];
  logic as_o [3], ac_o [3], er_o [3];

  sirq_upstream_sel uut (.clk, .rst_n, .cfg_wr, .cfg_num, .cfg_type, .ac_wr, .ac_val,
    .leg_en_a, .leg_en_b, .trig, .sw_set, .sw_clr, .obf,
    .irq_line(line[0]), .assert_q(as_o[0]), .autoclr(ac_o[0]), .cfg_err(er_o[0]));
  sirq_upstream_sel #(.LEVEL_ONLY(1'b1)) uut_lvl (.clk, .rst_n, .cfg_wr, .cfg_num, .cfg_type,
    .ac_wr, .ac_val, .leg_en_a, .leg_en_b, .trig, .sw_set, .sw_clr, .obf,
    .irq_line(line[1]), .assert_q(as_o[1]), .autoclr(ac_o[1]), .cfg_err(er_o[1]));
  sirq_upstream_sel #(.LEGACY(1'b1)) uut_leg (.clk, .rst_n, .cfg_wr, .cfg_num, .cfg_type,
    .ac_wr, .ac_val, .leg_en_a, .leg_en_b, .trig, .sw_set, .sw_clr, .obf,
    .irq_line(line[2]), .assert_q(as_o[2]), .autoclr(ac_o[2]), .cfg_err(er_o[2]));

  int n_chk = 0, n_bad = 0;
  bit m_ok [3], m_as [3], m_ac [3], m_er [3];
  logic [3:0] m_id [3];
  logic [1:0] m_ty [3];
  bit m_obfq;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_line(int i);
    logic [15:0] v = '0;
    if (i == 2) begin
      v[1]  = m_as[i] & leg_en_a;
      v[12] = m_as[i] & leg_en_b;
    end else if (m_ok[i]) begin
      v[m_id[i]] = (m_ty[i] == 2'b00) ? ~m_as[i] : m_as[i];
    end
    return v;
  endfunction

  task automatic model_step();
    bit fall = m_obfq & ~obf;
    for (int i = 0; i < 3; i++) begin
      bit lo = (i == 1);
      bit bad = (cfg_num > 15) || (cfg_type == 2'b10) || (lo && cfg_type == 2'b11);
      bit setr = trig | sw_set;
      if (!rst_n) begin
        m_ok[i] = 0; m_as[i] = 0; m_ac[i] = 0; m_er[i] = 0; m_id[i] = 0; m_ty[i] = 0;
      end else if (cfg_wr) begin
        m_ok[i] = !bad; m_as[i] = 0; m_ac[i] = 0; m_er[i] = m_er[i] | bad;
        if (!bad) begin m_id[i] = cfg_num[3:0]; m_ty[i] = cfg_type; end
      end else begin
        bit clr = sw_clr | (fall & (lo | m_ac[i]));
        if (ac_wr && !lo) m_ac[i] = ac_val;
        if (i != 2 && m_ty[i] == 2'b11) m_as[i] = setr;
        else if (setr) m_as[i] = 1;
        else if (clr) m_as[i] = 0;
      end
    end
    m_obfq = rst_n ? obf : 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R3 line vs model", line[i], exp_line(i));
      chk("R4 assert vs model", {15'd0, as_o[i]}, {15'd0, m_as[i]});
      chk("R8 autoclr vs model", {15'd0, ac_o[i]}, {15'd0, m_ac[i]});
      chk("R6 err vs model", {15'd0, er_o[i]}, {15'd0, m_er[i]});
    end
  endtask

  task automatic idle();
    cfg_wr = 0; ac_wr = 0; trig = 0; sw_set = 0; sw_clr = 0;
  endtask

  task automatic cfg(int num, int ty);
    cfg_wr = 1; cfg_num = 5'(num); cfg_type = 2'(ty); tick(); idle();
  endtask

  task automatic pulse_trig();
    trig = 1; tick(); idle();
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R1 reset line", line[0], 16'h0000);
    chk("R1 reset flags", {13'd0, as_o[0], ac_o[0], er_o[0]}, 16'h0);

    cfg(5, 1);
    chk("R2 selected idle high", line[0], 16'h0000);
    pulse_trig();
    chk("R3 active-high slot 5", line[0], 16'h0020);
    tick();
    chk("R4 level holds", line[0], 16'h0020);
    sw_clr = 1; tick(); idle();
    chk("R4 sw clear", line[0], 16'h0000);
    sw_set = 1; sw_clr = 1; tick(); idle();
    chk("R4 set wins", line[0], 16'h0020);
    cfg(5, 1);
    chk("R4 cfg disarms", {15'd0, as_o[0]}, 16'h0);

    cfg(7, 0);
    chk("R3 active-low idle", line[0], 16'h0080);
    pulse_trig();
    chk("R3 active-low asserted", line[0], 16'h0000);

    cfg(3, 3);
    chk("R7 level-only rejects edge err", {15'd0, er_o[1]}, 16'h1);
    chk("R6 full accepts edge", {15'd0, er_o[0]}, 16'h0);
    pulse_trig();
    chk("R5 edge pulse", line[0], 16'h0008);
    chk("R7 level-only quiet", line[1], 16'h0000);
    tick();
    chk("R5 edge one cycle", line[0], 16'h0000);

    cfg(3, 2);
    chk("R6 reserved err", {15'd0, er_o[0]}, 16'h1);
    pulse_trig();
    chk("R6 reserved quiet", line[0], 16'h0000);
    cfg(17, 1);
    pulse_trig();
    chk("R2 out of range quiet", line[0], 16'h0000);
    cfg(15, 1);
    pulse_trig();
    chk("R2 slot 15", line[0], 16'h8000);
    tick();
    chk("R6 err sticky", {15'd0, er_o[0]}, 16'h1);

    obf = 1; tick();
    ac_wr = 1; ac_val = 1; tick(); idle();
    chk("R8 autoclr set", {15'd0, ac_o[0]}, 16'h1);
    chk("R8 level-only autoclr zero", {15'd0, ac_o[1]}, 16'h0);
    obf = 0; tick();
    chk("R8 obf fall clears", line[0], 16'h0000);
    pulse_trig();
    ac_wr = 1; ac_val = 0; tick(); idle();
    obf = 1; tick(); obf = 0; tick();
    chk("R8 obf fall ignored", line[0], 16'h8000);
    ac_wr = 1; ac_val = 1; tick(); idle();
    cfg(15, 1);
    chk("R8 cfg clears autoclr", {15'd0, ac_o[0]}, 16'h0);

    leg_en_a = 1; leg_en_b = 1;
    pulse_trig();
    chk("R9 legacy both", line[2], 16'h1002);
    leg_en_b = 0; tick();
    chk("R9 legacy slot 1 only", line[2], 16'h0002);

    for (int k = 0; k < 4000; k++) begin
      cfg_wr   = ($urandom_range(7) == 0);
      cfg_num  = 5'($urandom_range(19));
      cfg_type = 2'($urandom_range(3));
      ac_wr    = ($urandom_range(7) == 0);
      ac_val   = 1'($urandom_range(1));
      leg_en_a = 1'($urandom_range(1));
      leg_en_b = 1'($urandom_range(1));
      trig     = ($urandom_range(5) == 0);
      sw_set   = ($urandom_range(9) == 0);
      sw_clr   = ($urandom_range(9) == 0);
      if ($urandom_range(3) == 0) obf = ~obf;
      tick();
    end
    idle();
    tick();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule